// File: doc/BRIEF.md
# Four-Opcode Instruction Decoder

This block turns one 12-bit instruction word of a small 4-bit single-cycle processor into every control signal its datapath needs in the same cycle. It is purely combinational. Inside, the 2-bit opcode becomes a one-hot four-bit operation vector. The operation set is add, negate, immediate move and jump-if-zero. From that vector the block drives the destination register address, the register write enable, the write-back source select, the immediate value, two operand register selects, the add/subtract select, the next-PC select and the jump target.

The jump decision is made inside the decoder. The value of the register named in the destination field comes in on a separate input. The next-PC select is 1 for the sequential path and 0 for a taken jump. The register file, the arithmetic unit and the program counter are outside this block.

Field layout of the instruction word: opcode in [11:10], register field A in [9:7], register field B in [6:4], immediate in [3:0]. The jump target is the low three bits of the immediate.

Top module: `nd_decoder`

## Requirements
- R1: The opcode in bits [11:10] selects the operation: 00 add, 01 negate, 10 move immediate, 11 jump if zero. Exactly one operation is active for any instruction word.
- R2: `dst_sel_o` always equals instruction bits [9:7], for every opcode.
- R3: `imm_o` always equals instruction bits [3:0], for every opcode.
- R4: `wb_alu_o` is 1 for add and negate, and 0 for move and jump.
- R5: `sub_o` is 1 only for negate, and 0 for the other three opcodes.
- R6: For add, move and jump, `opa_sel_o` equals bits [9:7] and `opb_sel_o` equals bits [6:4].
- R7: For negate, `opa_sel_o` is 000, which selects the constant-zero register, and `opb_sel_o` equals bits [9:7]. The arithmetic unit then forms 0 minus register A.
- R8: `wr_en_o` is 1 for add, negate and move, and 0 for jump.
- R9: `seq_o` is 0 only when the opcode is 11 and `ra_val_i` is 0000. Otherwise it is 1.
- R10: For opcodes 00, 01 and 10, `ra_val_i` has no effect: `seq_o` stays 1 for every value of it.
- R11: `jmp_addr_o` always equals instruction bits [2:0], for every opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 12 | Instruction word |
| ra_val_i | input | 4 | Current value of the register named by bits [9:7] |
| dst_sel_o | output | 3 | Destination register address |
| wr_en_o | output | 1 | Register write enable |
| wb_alu_o | output | 1 | Write-back source: 0 immediate, 1 arithmetic result |
| imm_o | output | 4 | Immediate value |
| opa_sel_o | output | 3 | Register select for arithmetic operand A |
| opb_sel_o | output | 3 | Register select for arithmetic operand B |
| sub_o | output | 1 | Arithmetic select: 0 add, 1 subtract |
| seq_o | output | 1 | Next-PC select: 1 sequential, 0 jump |
| jmp_addr_o | output | 3 | Jump target address |

## Verification
Every output depends only on the present inputs, so each result is due zero cycles after its stimulus. The bench applies a new instruction and register value just after a rising edge. It compares all outputs with its behavioural model at the following falling edge, half a period later, when the combinational paths have settled and no clock edge is pending. The stimulus covers a directed set for each opcode, a sweep of all sixteen register values under every opcode, and a pseudo-random run over the whole instruction space. One input pair is compared per clock.

// File: rtl/nd_pkg.sv
// Package: shared operation indices for the instruction decoder.
// Assumes a one-hot operation vector ordered add, negate, move, jump.
package nd_pkg;
    localparam int OPS_N = 4;
    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_NEG = 2'b01,
        OP_MOV = 2'b10,
        OP_JMP = 2'b11
    } op_e;
    localparam int IX_ADD = 0;
    localparam int IX_NEG = 1;
    localparam int IX_MOV = 2;
    localparam int IX_JMP = 3;
endpackage

// File: rtl/nd_op_expand.sv
// Expands a binary opcode into a one-hot operation vector.
// Assumes every opcode value names exactly one operation.
module nd_op_expand #(
    parameter int OPC_W = 2,
    localparam int NOPS = 1 << OPC_W
) (
    input  logic [OPC_W-1:0] opc_i,
    output logic [NOPS-1:0]  onehot_o
);
    // One comparator per operation slot.
    for (genvar g = 0; g < NOPS; g++) begin : g_slot
        assign onehot_o[g] = (opc_i == OPC_W'(g));
    end
endmodule

// File: rtl/nd_operand_route.sv
// Picks the two operand register selects.
// Negate routes the constant-zero register to A and field A to B,
// so the arithmetic unit forms 0 - Ra. Other operations pass fields through.
module nd_operand_route #(
    parameter int RAW = 3
) (
    input  logic           is_neg_i,
    input  logic [RAW-1:0] fa_i,
    input  logic [RAW-1:0] fb_i,
    output logic [RAW-1:0] opa_o,
    output logic [RAW-1:0] opb_o
);
    // Operand steering by operation.
    always_comb begin
        if (is_neg_i) begin
            opa_o = '0;
            opb_o = fa_i;
        end else begin
            opa_o = fa_i;
            opb_o = fb_i;
        end
    end
endmodule

// File: rtl/nd_branch_resolve.sv
// Resolves jump-if-zero: next-PC select is 1 for sequential, 0 for jump.
// Assumes the register value is only meaningful when is_jump_i is high.
module nd_branch_resolve #(
    parameter int DATA_W = 4,
    parameter int PC_W   = 3
) (
    input  logic              is_jump_i,
    input  logic [DATA_W-1:0] reg_val_i,
    input  logic [PC_W-1:0]   tgt_field_i,
    output logic              seq_o,
    output logic [PC_W-1:0]   tgt_o
);
    logic reg_zero;

    // Zero test of the register operand.
    always_comb reg_zero = (reg_val_i == '0);

    // Taken only for a jump whose register is zero.
    always_comb seq_o = !(is_jump_i && reg_zero);

    // Target is passed through unconditionally.
    always_comb tgt_o = tgt_field_i;
endmodule

// File: rtl/nd_decoder.sv
// Top: combinational decoder for a four-operation 4-bit processor.
// Word layout: opcode | field A | field B | immediate, high to low.
// Assumes the PC width does not exceed the immediate width.
module nd_decoder #(
    parameter int OPC_W  = 2,
    parameter int RAW    = 3,
    parameter int DATA_W = 4,
    parameter int PC_W   = 3,
    localparam int IMM_W   = DATA_W,
    localparam int INSTR_W = OPC_W + 2*RAW + IMM_W,
    localparam int FB_LO   = IMM_W,
    localparam int FA_LO   = IMM_W + RAW,
    localparam int OP_LO   = IMM_W + 2*RAW,
    localparam int NOPS    = 1 << OPC_W
) (
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [DATA_W-1:0]  ra_val_i,
    output logic [RAW-1:0]     dst_sel_o,
    output logic               wr_en_o,
    output logic               wb_alu_o,
    output logic [IMM_W-1:0]   imm_o,
    output logic [RAW-1:0]     opa_sel_o,
    output logic [RAW-1:0]     opb_sel_o,
    output logic               sub_o,
    output logic               seq_o,
    output logic [PC_W-1:0]    jmp_addr_o
);
    import nd_pkg::*;

    logic [OPC_W-1:0] opc;
    logic [RAW-1:0]   fa, fb;
    logic [NOPS-1:0]  op_vec;

    // Field extraction.
    always_comb begin
        opc   = instr_i[OP_LO +: OPC_W];
        fa    = instr_i[FA_LO +: RAW];
        fb    = instr_i[FB_LO +: RAW];
        imm_o = instr_i[IMM_W-1:0];
    end

    nd_op_expand #(.OPC_W(OPC_W)) u_expand (
        .opc_i    (opc),
        .onehot_o (op_vec)
    );

    // Register-file and arithmetic controls from the operation vector.
    always_comb begin
        dst_sel_o = fa;
        wr_en_o   = op_vec[IX_ADD] | op_vec[IX_NEG] | op_vec[IX_MOV];
        wb_alu_o  = op_vec[IX_ADD] | op_vec[IX_NEG];
        sub_o     = op_vec[IX_NEG];
    end

    nd_operand_route #(.RAW(RAW)) u_route (
        .is_neg_i (op_vec[IX_NEG]),
        .fa_i     (fa),
        .fb_i     (fb),
        .opa_o    (opa_sel_o),
        .opb_o    (opb_sel_o)
    );

    nd_branch_resolve #(.DATA_W(DATA_W), .PC_W(PC_W)) u_branch (
        .is_jump_i   (op_vec[IX_JMP]),
        .reg_val_i   (ra_val_i),
        .tgt_field_i (instr_i[PC_W-1:0]),
        .seq_o       (seq_o),
        .tgt_o       (jmp_addr_o)
    );
endmodule

// File: rtl/nd_decoder_chk.sv
// Checker for nd_decoder: relates ports and the internal operation vector.
// Assumes the default field widths; combinational, so immediate assertions.
module nd_decoder_chk (
    input logic [11:0] instr_i,
    input logic [3:0]  ra_val_i,
    input logic [2:0]  dst_sel_o,
    input logic        wr_en_o,
    input logic        wb_alu_o,
    input logic [3:0]  imm_o,
    input logic [2:0]  opa_sel_o,
    input logic [2:0]  opb_sel_o,
    input logic        sub_o,
    input logic        seq_o,
    input logic [2:0]  jmp_addr_o,
    input logic [3:0]  op_vec
);
    // Continuous consistency checks between inputs and decoded outputs.
    always_comb begin
        AST_OP_ONEHOT: assert ($countones(op_vec) == 1) else $error("op vector not one-hot"); // R1
        AST_DST_FIELD: assert (dst_sel_o == instr_i[9:7]) else $error("dst mismatch"); // R2
        AST_IMM_FIELD: assert (imm_o == instr_i[3:0]) else $error("imm mismatch"); // R3
        AST_WB_SRC: assert (wb_alu_o == !instr_i[11]) else $error("wb select wrong"); // R4
        AST_SUB_NEG: assert (sub_o == (instr_i[11:10] == 2'b01)) else $error("sub wrong"); // R5
        AST_NEG_ROUTE: assert (!sub_o || (opa_sel_o == 3'd0 && opb_sel_o == dst_sel_o)) else $error("neg route wrong"); // R7
        AST_PASS_ROUTE: assert (sub_o || (opa_sel_o == instr_i[9:7] && opb_sel_o == instr_i[6:4])) else $error("pass route wrong"); // R6
        AST_WR_EN: assert (wr_en_o == (instr_i[11:10] != 2'b11)) else $error("write enable wrong"); // R8
        AST_JUMP_TAKEN: assert (seq_o || (instr_i[11:10] == 2'b11 && ra_val_i == 4'd0)) else $error("spurious jump"); // R9
        AST_NONJUMP_SEQ: assert ((instr_i[11:10] == 2'b11) || seq_o) else $error("non-jump left sequence"); // R10
        AST_JMP_ADDR: assert (jmp_addr_o == instr_i[2:0]) else $error("target mismatch"); // R11
    end
endmodule

bind nd_decoder nd_decoder_chk u_chk (
    .instr_i    (instr_i),
    .ra_val_i   (ra_val_i),
    .dst_sel_o  (dst_sel_o),
    .wr_en_o    (wr_en_o),
    .wb_alu_o   (wb_alu_o),
    .imm_o      (imm_o),
    .opa_sel_o  (opa_sel_o),
    .opb_sel_o  (opb_sel_o),
    .sub_o      (sub_o),
    .seq_o      (seq_o),
    .jmp_addr_o (jmp_addr_o),
    .op_vec     (op_vec)
);

// File: tb/sim_nd_decoder.sv
`timescale 1ns/1ps
// Bench: behavioural reference compared with the decoder once per clock.
module sim_nd_decoder;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [11:0] instr;
    logic [3:0]  ra_val;
    logic [2:0]  dst_sel, opa_sel, opb_sel, jmp_addr;
    logic        wr_en, wb_alu, sub, seq;
    logic [3:0]  imm;

    int n_cmp = 0;
    int n_bad = 0;
    logic done = 1'b0;

    nd_decoder u0 (
        .instr_i    (instr),
        .ra_val_i   (ra_val),
        .dst_sel_o  (dst_sel),
        .wr_en_o    (wr_en),
        .wb_alu_o   (wb_alu),
        .imm_o      (imm),
        .opa_sel_o  (opa_sel),
        .opb_sel_o  (opb_sel),
        .sub_o      (sub),
        .seq_o      (seq),
        .jmp_addr_o (jmp_addr)
    );

    // Single comparison with report on mismatch.
    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s instr=%03h ra=%0d actual=%0d expected=%0d",
                     req, what, instr, ra_val, act, exp);
        end
    endtask

    // Behavioural reference for all outputs of the current inputs.
    task automatic compare_all();
        int op;
        int fa;
        int fb;
        int e_wr;
        int e_wb;
        int e_sub;
        int e_opa;
        int e_opb;
        int e_seq;
        op = instr[11:10];
        fa = instr[9:7];
        fb = instr[6:4];
        case (op)
            0: begin e_wr = 1; e_wb = 1; e_sub = 0; e_opa = fa; e_opb = fb; end
            1: begin e_wr = 1; e_wb = 1; e_sub = 1; e_opa = 0;  e_opb = fa; end
            2: begin e_wr = 1; e_wb = 0; e_sub = 0; e_opa = fa; e_opb = fb; end
            default: begin e_wr = 0; e_wb = 0; e_sub = 0; e_opa = fa; e_opb = fb; end
        endcase
        e_seq = (op == 3 && ra_val == 0) ? 0 : 1;
        chk("R2", "dst", dst_sel, fa);
        chk("R3", "imm", imm, instr[3:0]);
        chk("R4", "wb", wb_alu, e_wb);
        chk("R5", "sub", sub, e_sub);
        chk(op == 1 ? "R7" : "R6", "opa", opa_sel, e_opa);
        chk(op == 1 ? "R7" : "R6", "opb", opb_sel, e_opb);
        chk("R8", "wr_en", wr_en, e_wr);
        chk(op == 3 ? "R9" : "R10", "seq", seq, e_seq);
        chk("R11", "jmp", jmp_addr, instr[2:0]);
        chk("R1", "op-class", {wr_en, wb_alu, sub}, (e_wr << 2) | (e_wb << 1) | e_sub);
    endtask

    // Apply after a rising edge, compare at the next falling edge.
    task automatic apply(input logic [11:0] i, input logic [3:0] r);
        @(posedge clk);
        #1;
        instr = i;
        ra_val = r;
        @(negedge clk);
        compare_all();
    endtask

    // Watchdog: a hung run counts as a failure and still summarises.
    initial begin
        #3000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Stimulus sequence.
    initial begin
        logic [31:0] lcg;
        instr = '0;
        ra_val = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare_all(); // reset state: ADD R0,R0 (R1)
        rst_n = 1'b1;
        // Directed cases per opcode.
        apply(12'b10_001_000_0001, 4'd5);  // MOV R1,1  R1 R3
        apply(12'b00_111_001_0000, 4'd0);  // ADD R7,R1 with zero reg: R10
        apply(12'b01_101_110_1010, 4'd0);  // NEG R5: R7 R10
        apply(12'b11_000_000_0110, 4'd0);  // jump taken R9
        apply(12'b11_011_101_1101, 4'd1);  // jump not taken R9
        apply(12'b11_111_111_1111, 4'd15); // all ones R11
        // Register-value sweep under every opcode: R9 R10.
        for (int op = 0; op < 4; op++) begin
            for (int r = 0; r < 16; r++) begin
                apply({op[1:0], 3'd6, 3'd2, 4'd11}, r[3:0]);
            end
        end
        // Pseudo-random run across the word space.
        lcg = 32'h1234_5678;
        for (int k = 0; k < 3000; k++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            apply(lcg[27:16], (lcg[31:30] == 2'b00) ? 4'd0 : lcg[7:4]);
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule